// File: doc/BRIEF.md
# Flash Ready Flag Poller

This block sits on the host side of a serial NOR flash link and waits for the device to finish an internal job, such as a program, an erase, a suspend or resume, or a reset given while the device was busy. After a pulse on `start`, the block runs a series of read transactions. Chip select frames each one. Every transaction sends the flag-status read opcode (0x70) and then captures one returned byte. The block stops as soon as bit 7 of that byte shows the device is ready. Commands are sent and the reply is taken over one, two or four lanes of a shared 4-bit data bus. Separate output-enable bits say which lanes the host is driving.

Devices built from two dies report ready once for each die. For them, `two_die` can be set so that completion needs two back-to-back framed reads that both show bit 7 set. A busy reply from either die starts the count again. Chip select is held high for a programmable minimum number of system clocks between reads. An optional limit on the number of reads ends the search with a timeout flag. The serial clock is the system clock divided down. The host drives data on its falling edge and samples on its rising edge.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `dq_oe` is 0, and `busy`, `done` and `timeout` are all 0.
- R2: Each frame starts with the byte 0x70, MSB first. The lane mode sets how it is sent. For 0 (single), one bit per clock goes on dq[0]. For 1 (dual), two bits go on dq[1:0], with dq[1] carrying the higher bit. For 2 (quad), four bits go on dq[3:0], with dq[3] carrying the higher bit. While the opcode is being sent, `dq_oe` is 0001, 0011 or 1111, matching the mode.
- R3: The reply byte is sampled MSB first on rising `sck` edges. Single mode reads it from dq_in[1], dual from dq_in[1:0] and quad from dq_in[3:0], with the higher lane carrying the higher bit. `flag_byte` holds the byte from the most recent frame.
- R4: `sck` rests low while `cs_n` is high. Each frame gives exactly 16, 8 or 4 rising edges in single, dual or quad mode. Each half period of `sck` lasts DIV system clocks.
- R5: With `two_die` at 0, a reply with bit 7 = 1 ends polling with `done` = 1. A reply with bit 7 = 0 leads to another frame.
- R6: With `two_die` at 1, `done` rises only after two back-to-back frames both return bit 7 = 1. A frame with bit 7 = 0 clears the count of consecutive ready replies.
- R7: Between two frames of one run, `cs_n` stays high for at least `gap_clks` system clocks.
- R8: If `poll_limit` is non-zero and that many frames finish without completion, `timeout` goes to 1 and no further frame starts. A `poll_limit` of 0 means there is no limit.
- R9: If the frame that reaches the limit also completes the ready condition, `done` is set and `timeout` stays 0.
- R10: A `start` pulse while `busy` is 1 has no effect. A `start` pulse while idle clears `done` and `timeout`. `done` and `timeout` hold their value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| lane_mode | input | 2 | 0 single, 1 dual, 2 quad (latched at start) |
| two_die | input | 1 | Require two consecutive ready replies |
| gap_clks | input | GAP_W | Minimum chip-select-high clocks between frames |
| poll_limit | input | POLL_W | Maximum frames per run, 0 = unlimited |
| dq_in | input | 4 | Data lanes from the device |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 4 | Data lanes towards the device |
| dq_oe | output | 4 | Per-lane output enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Device reported ready |
| timeout | output | 1 | Read limit reached without completion |
| flag_byte | output | 8 | Last flag byte received |

## Verification
Two outcomes can fall in the same cycle: the ready condition can be met on the very frame that uses up the read limit. The bench sets this up by choosing the limit to equal the index of the frame that completes the condition. It does this once for a single-die run and once for a two-die pair that closes on the last allowed frame. It also runs a two-die case where the limit cuts the pair in half. In the first two cases it expects `done` with `timeout` low. In the last case it expects `timeout`, and it counts frames to confirm that no extra read was started.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_EVAL = 2'd2,
    ST_GAP  = 2'd3
  } poll_st_e;

  // beats (sck rising edges) needed to move one byte
  function automatic logic [4:0] beats_per_byte(input logic [1:0] mode);
    case (mode)
      2'd1:    beats_per_byte = 5'd4;
      2'd2:    beats_per_byte = 5'd2;
      default: beats_per_byte = 5'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] mode);
    case (mode)
      2'd1:    lane_mask = 4'b0011;
      2'd2:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/frp_sclk_gen.sv
module frp_sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick = run && (cnt_q == CW'(DIV - 1));
  assign rise = tick && !sck_q;
  assign fall = tick && sck_q;
  assign sck  = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = !sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end
endmodule

// File: rtl/frp_lane_shifter.sv
module frp_lane_shifter #(
  parameter logic [7:0] OPCODE = 8'h70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] mode,
  input  logic       shift_out,
  input  logic       shift_in,
  input  logic [3:0] dq_in,
  output logic [3:0] lanes_out,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q, tx_d;
  logic [7:0] rx_q, rx_d;

  always_comb begin
    case (mode)
      2'd1:    lanes_out = {2'b00, tx_q[7:6]};
      2'd2:    lanes_out = tx_q[7:4];
      default: lanes_out = {3'b000, tx_q[7]};
    endcase
  end

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = OPCODE;
      rx_d = '0;
    end else begin
      if (shift_out) begin
        case (mode)
          2'd1:    tx_d = {tx_q[5:0], 2'b00};
          2'd2:    tx_d = {tx_q[3:0], 4'b0000};
          default: tx_d = {tx_q[6:0], 1'b0};
        endcase
      end
      if (shift_in) begin
        case (mode)
          2'd1:    rx_d = {rx_q[5:0], dq_in[1:0]};
          2'd2:    rx_d = {rx_q[3:0], dq_in[3:0]};
          default: rx_d = {rx_q[6:0], dq_in[1]};
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign rx_byte = rx_q;
endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import frp_pkg::*;
#(
  parameter int         DIV    = 2,
  parameter int         GAP_W  = 8,
  parameter int         POLL_W = 16,
  parameter logic [7:0] OPCODE = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        lane_mode,
  input  logic              two_die,
  input  logic [GAP_W-1:0]  gap_clks,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [3:0]        dq_in,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [7:0]        flag_byte
);
  poll_st_e          st_q, st_d;
  logic [1:0]        mode_q, mode_d;
  logic              two_q, two_d;
  logic [GAP_W-1:0]  gap_q, gap_d, gcnt_q, gcnt_d;
  logic [POLL_W-1:0] lim_q, lim_d, pcnt_q, pcnt_d;
  logic [1:0]        rdy_q, rdy_d;
  logic [4:0]        beat_q, beat_d;
  logic              oe_q, oe_d;
  logic              done_q, done_d, to_q, to_d;
  logic [7:0]        flag_q, flag_d;

  logic       run, s_rise, s_fall;
  logic       load;
  logic [3:0] lanes_out;
  logic [7:0] rx_byte;
  logic [4:0] nb;

  assign nb  = beats_per_byte(mode_q);
  assign run = (st_q == ST_XFER);

  frp_sclk_gen #(.DIV(DIV)) u_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sck  (sck),
    .rise (s_rise),
    .fall (s_fall)
  );

  frp_lane_shifter #(.OPCODE(OPCODE)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .mode     (mode_q),
    .shift_out(s_fall && (beat_q < nb)),
    .shift_in (s_rise && (beat_q >= nb)),
    .dq_in    (dq_in),
    .lanes_out(lanes_out),
    .rx_byte  (rx_byte)
  );

  // evaluation of the byte just received
  logic              is_ready, finished, limit_hit;
  logic [1:0]        rdy_next;
  logic [POLL_W-1:0] pcnt_inc;

  always_comb begin
    is_ready  = rx_byte[7];
    rdy_next  = is_ready ? (rdy_q + 2'd1) : 2'd0;
    finished  = is_ready && (rdy_next >= (two_q ? 2'd2 : 2'd1));
    pcnt_inc  = pcnt_q + 1'b1;
    limit_hit = (lim_q != '0) && (pcnt_inc >= lim_q);
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    two_d  = two_q;
    gap_d  = gap_q;
    lim_d  = lim_q;
    gcnt_d = gcnt_q;
    pcnt_d = pcnt_q;
    rdy_d  = rdy_q;
    beat_d = beat_q;
    oe_d   = oe_q;
    done_d = done_q;
    to_d   = to_q;
    flag_d = flag_q;
    load   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          mode_d = (lane_mode == 2'd3) ? 2'd0 : lane_mode;
          two_d  = two_die;
          gap_d  = gap_clks;
          lim_d  = poll_limit;
          pcnt_d = '0;
          rdy_d  = '0;
          done_d = 1'b0;
          to_d   = 1'b0;
          beat_d = '0;
          oe_d   = 1'b1;
          load   = 1'b1;
          st_d   = ST_XFER;
        end
      end
      ST_XFER: begin
        if (s_rise) beat_d = beat_q + 5'd1;
        if (s_fall && (beat_q == nb)) oe_d = 1'b0;
        if (s_fall && (beat_q == (nb << 1))) st_d = ST_EVAL;
      end
      ST_EVAL: begin
        flag_d = rx_byte;
        pcnt_d = pcnt_inc;
        rdy_d  = rdy_next;
        gcnt_d = '0;
        if (finished) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (limit_hit) begin
          to_d = 1'b1;
          st_d = ST_IDLE;
        end else begin
          st_d = ST_GAP;
        end
      end
      default: begin
        gcnt_d = gcnt_q + 1'b1;
        if ((gcnt_q + 1'b1) >= gap_q) begin
          beat_d = '0;
          oe_d   = 1'b1;
          load   = 1'b1;
          st_d   = ST_XFER;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      two_q  <= 1'b0;
      gap_q  <= '0;
      lim_q  <= '0;
      gcnt_q <= '0;
      pcnt_q <= '0;
      rdy_q  <= '0;
      beat_q <= '0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      flag_q <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      two_q  <= two_d;
      gap_q  <= gap_d;
      lim_q  <= lim_d;
      gcnt_q <= gcnt_d;
      pcnt_q <= pcnt_d;
      rdy_q  <= rdy_d;
      beat_q <= beat_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      to_q   <= to_d;
      flag_q <= flag_d;
    end
  end

  assign cs_n      = !run;
  assign dq_oe     = oe_q ? lane_mask(mode_q) : 4'b0000;
  assign dq_out    = oe_q ? lanes_out : 4'b0000;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign timeout   = to_q;
  assign flag_byte = flag_q;
endmodule

// File: rtl/frp_chk.sv
module frp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] dq_oe,
  input logic       busy,
  input logic       done,
  input logic       timeout
);
  // R4
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'b0000));

  // R9
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  // R1
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  // R10
  to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !start) |=> timeout);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind flash_ready_poller frp_chk u_frp_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .sck    (sck),
  .cs_n   (cs_n),
  .dq_oe  (dq_oe),
  .busy   (busy),
  .done   (done),
  .timeout(timeout)
);

// File: tb/flash_ready_poller_test.sv
`timescale 1ns/1ps
module flash_ready_poller_test;
  logic        clk, rst_n, start, two_die;
  logic [1:0]  lane_mode;
  logic [7:0]  gap_clks;
  logic [15:0] poll_limit;
  logic [3:0]  dq_in;
  logic        sck, cs_n, busy, done, timeout;
  logic [3:0]  dq_out, dq_oe;
  logic [7:0]  flag_byte;

  int n_chk = 0, n_bad = 0;

  flash_ready_poller uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mode(lane_mode),
    .two_die(two_die), .gap_clks(gap_clks), .poll_limit(poll_limit),
    .dq_in(dq_in), .sck(sck), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .busy(busy), .done(done), .timeout(timeout), .flag_byte(flag_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] resp [0:15];
  int   frames, rises, lanes, nbeat;
  logic [7:0] cmd_sh;
  logic [3:0] mask;
  bit   armed;
  realtime t_cs_up;

  always @(negedge cs_n) if (armed) begin
    if (frames > 0)
      check("R7 gap", int'((($realtime - t_cs_up) + 0.1) / 5.0) >= int'(gap_clks), 1);
    rises  = 0;
    cmd_sh = 8'h00;
  end

  always @(posedge sck) if (armed && !cs_n) begin
    if (rises < nbeat) begin
      cmd_sh = (cmd_sh << lanes) | 8'(dq_out & mask);
      check("R2 oe", dq_oe, mask);
    end
    rises++;
  end

  always @(negedge sck) if (armed && !cs_n && rises >= nbeat && rises < 2*nbeat) begin
    logic [7:0] b;
    logic [3:0] ch;
    b  = resp[frames > 15 ? 15 : frames];
    ch = 4'((b >> (8 - lanes*(rises - nbeat + 1))) & 8'(mask));
    dq_in = (lanes == 1) ? {2'b00, ch[0], 1'b0} : ch;
  end

  always @(posedge cs_n) if (armed) begin
    check("R2 opcode", cmd_sh, 8'h70);
    check("R4 beats", rises, 2*nbeat);
    t_cs_up = $realtime;
    frames++;
    dq_in = 4'h0;
  end

  // ---------------- helpers ----------------
  task automatic setup(input logic [1:0] m, input logic two, input int gap, input int lim);
    @(negedge clk);
    lane_mode = m; two_die = two; gap_clks = 8'(gap); poll_limit = 16'(lim);
    lanes = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    nbeat = 8 / lanes;
    mask  = (m == 2'd1) ? 4'b0011 : (m == 2'd2) ? 4'b1111 : 4'b0001;
    frames = 0;
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
  endtask

  task automatic go_and_wait();
    int cyc;
    start = 1'b1; @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!(done || timeout) && cyc < 5000) begin @(negedge clk); cyc++; end
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 cs_n", cs_n, 1); check("R1 sck", sck, 0);
    check("R1 oe", dq_oe, 0); check("R1 busy", busy, 0);
    check("R1 done", done, 0); check("R1 timeout", timeout, 0);
  endtask

  task automatic t_single(input logic [1:0] m, input logic [7:0] last);
    setup(m, 1'b0, 3, 0);
    resp[2] = last;
    go_and_wait();
    check("R5 done", done, 1); check("R5 frames", frames, 3);
    check("R3 flag_byte", flag_byte, last); check("R5 busy", busy, 0);
  endtask

  task automatic t_two_die();
    setup(2'd1, 1'b1, 2, 0);
    resp[0] = 8'h80; resp[1] = 8'h00; resp[2] = 8'h81; resp[3] = 8'hC0;
    go_and_wait();
    check("R6 done", done, 1); check("R6 frames", frames, 4);
    check("R3 flag_byte", flag_byte, 8'hC0);
  endtask

  task automatic t_timeout();
    setup(2'd0, 1'b0, 4, 4);
    go_and_wait();
    check("R8 timeout", timeout, 1); check("R8 done", done, 0);
    repeat (300) @(negedge clk);
    check("R8 no more frames", frames, 4); check("R8 cs_n", cs_n, 1);
  endtask

  task automatic t_coincide();
    setup(2'd2, 1'b0, 1, 3);
    resp[2] = 8'h80;
    go_and_wait();
    check("R9 single done", done, 1); check("R9 single timeout", timeout, 0);
    setup(2'd0, 1'b1, 1, 3);
    resp[1] = 8'h80; resp[2] = 8'h80;
    go_and_wait();
    check("R9 pair done", done, 1); check("R9 pair timeout", timeout, 0);
    setup(2'd0, 1'b1, 1, 2);
    resp[1] = 8'h80;
    go_and_wait();
    check("R9 split timeout", timeout, 1); check("R9 split frames", frames, 2);
  endtask

  task automatic t_start_rules();
    setup(2'd1, 1'b0, 2, 0);
    resp[3] = 8'h80;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R10 busy start ignored", frames, 4);
    repeat (20) @(negedge clk);
    check("R10 done held", done, 1);
    setup(2'd1, 1'b0, 2, 0);
    resp[0] = 8'h80;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R10 done cleared", done, 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dq_in = 4'h0; armed = 1'b0;
    lane_mode = 2'd0; two_die = 1'b0; gap_clks = 8'd1; poll_limit = 16'd0;
    lanes = 1; nbeat = 8; mask = 4'b0001; frames = 0; rises = 0; cmd_sh = 8'h00;
    t_cs_up = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1'b1;
    t_single(2'd0, 8'hA5);
    t_single(2'd1, 8'h81);
    t_single(2'd2, 8'hC3);
    t_two_die();
    t_timeout();
    t_coincide();
    t_start_rules();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule